// File: doc/BRIEF.md
# Smart card character transceiver

This block moves single characters over the one-wire, half-duplex line of an asynchronous smart card. A character is a low start bit, eight data bits and a parity bit. A slot follows the parity bit in which the receiving side may pull the line low to refuse the character. The block both sends and receives, but never both at once. The line is open-drain: the block only ever pulls it low or lets it go, and reads the resulting level back on `line_in`.

Three quasi-static configuration inputs select the convention: bit order (`cfg_msb_first`), inversion of the data levels (`cfg_inv_data`) and the parity sense (`cfg_odd_parity`). Direct convention clears all three. Inverse convention sets all three, because the data inversion leaves the parity level alone and the parity sense has to be flipped separately. Bit timing comes from `etu_div`, which is the number of clock cycles per bit period. It must be at least 4 and must not change while a character is in progress. Received bits are sampled in the middle of their period.

After the parity bit, the transmitter releases the line and watches the error slot. If the slot is low, it flags the character as rejected so that the next layer can resend it. The receiver checks parity, signals an error in the slot when parity fails, and then hands over the byte in logical order.

Top module: `sc_char_xcvr`

## Requirements
- R1: While rst_n is low, line_drive_low, tx_busy, rx_busy, tx_done, rx_valid and tx_rejected are all 0. Whenever no character is in progress, line_drive_low is 0 (line released).
- R2: A tx_start sampled high on a rising edge while tx_busy and rx_busy are low is accepted. For m = 0 to 12·E−1 cycles after that edge (E = etu_div), tx_busy is 1 and the line follows frame bit m/E: bit 0 is the start bit (low), bits 1 to 8 are data, bit 9 is parity, and bits 10 and 11 are released. tx_done is high only in the cycle after edge 12·E.
- R3: In direct convention (cfg_msb_first=0, cfg_inv_data=0, cfg_odd_parity=0), D0 is sent first and a high (released) level means 1. Byte 0x3B is sent as H H L H H H L L on frame bits 1 to 8, with H on the parity bit.
- R4: In inverse convention (all three config inputs 1), D7 is sent first and a low level means 1. Byte 0x3F is sent as H H L L L L L L with H on the parity bit, and that line pattern is received as 0x3F.
- R5: The parity level makes the number of high levels among the eight data levels plus parity even when cfg_odd_parity=0, and odd when it is 1. cfg_inv_data acts on the eight data levels only, and the parity rule applies to the levels that result.
- R6: The transmitter leaves the line released during frame bit 10 and samples it at cycle E/2 (integer division) of that bit. A low sample sets tx_rejected to 1 together with tx_done; otherwise tx_rejected is 0. tx_rejected then holds its value until the next accepted tx_start clears it.
- R7: The receiver arms on a low line only when it is idle, the transmitter is idle and tx_start is low. If the line is high again when the start bit is sampled at its middle, the receiver drops the character with no output and no drive.
- R8: Received bit k is sampled on edge k·E+E/2+1, counted from the edge that first saw the start bit low. rx_valid is high only in the cycle after edge 11·E, with rx_data in logical order after the convention's bit order and level inversion have been undone.
- R9: If the received levels break the rule of R5, the receiver drives the line low from edge 10·E until edge 11·E (E cycles) and reports rx_par_err=1 with rx_valid. If parity is correct, the slot stays released and rx_par_err=0.
- R10: tx_start is ignored while rx_busy is 1, and the receiver ignores the line while tx_busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| etu_div | input | ETU_W | Clock cycles per bit period (at least 4) |
| cfg_msb_first | input | 1 | Send and receive D7 first |
| cfg_inv_data | input | 1 | Low level means logical 1 on the data bits |
| cfg_odd_parity | input | 1 | Odd parity over the line levels |
| tx_start | input | 1 | Request to send tx_data |
| tx_data | input | 8 | Byte to send, in logical order |
| tx_busy | output | 1 | Transmit character in progress |
| tx_done | output | 1 | One-cycle pulse at the end of a transmit character |
| tx_rejected | output | 1 | The last sent character was refused in its error slot |
| rx_busy | output | 1 | Receive character in progress |
| rx_valid | output | 1 | One-cycle pulse with a received byte |
| rx_data | output | 8 | Received byte, in logical order |
| rx_par_err | output | 1 | The received byte failed its parity check |
| line_in | input | 1 | Level read back from the shared line |
| line_drive_low | output | 1 | 1 pulls the line low, 0 releases it |

## Verification
Every result is due a fixed number of edges after its trigger. For transmit, the trigger is the edge that accepts tx_start: frame bit k drives the line from edge k·E, and tx_done and tx_rejected arrive after edge 12·E. For receive, the trigger is the edge that first sees the start bit low: the error drive covers edges 10·E to 11·E, and rx_valid with rx_data arrives after edge 11·E. The bench turns each stimulus into expected values filed under these absolute edge counts. On every falling edge it compares the line drive, the busy flag and the pulses against that schedule, so a result that comes one cycle early or late is counted as a mismatch.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int SC_DATA_W   = 8;
  localparam int SC_IDX_W    = 4;
  localparam int SC_FRAME_W  = 1 << SC_IDX_W;
  localparam int SC_PAR_IDX  = SC_DATA_W + 1;
  localparam int SC_SLOT_IDX = SC_DATA_W + 2;
  localparam int SC_TX_LAST  = SC_DATA_W + 3;

  typedef struct packed {
    logic msb_first;
    logic inv_data;
    logic odd_par;
  } sc_cfg_t;

  // reverse the bit order when the convention sends D7 first
  function automatic logic [SC_DATA_W-1:0] sc_order(input logic [SC_DATA_W-1:0] d,
                                                    input logic msb_first);
    logic [SC_DATA_W-1:0] r;
    for (int i = 0; i < SC_DATA_W; i++) r[i] = d[SC_DATA_W-1-i];
    return msb_first ? r : d;
  endfunction

  // line levels in transmit order, index 0 leaves first (1 = released)
  function automatic logic [SC_DATA_W-1:0] sc_to_levels(input logic [SC_DATA_W-1:0] d,
                                                        input sc_cfg_t c);
    return sc_order(c.inv_data ? ~d : d, c.msb_first);
  endfunction

  // inverse of sc_to_levels
  function automatic logic [SC_DATA_W-1:0] sc_from_levels(input logic [SC_DATA_W-1:0] lv,
                                                          input sc_cfg_t c);
    logic [SC_DATA_W-1:0] o;
    o = sc_order(lv, c.msb_first);
    return c.inv_data ? ~o : o;
  endfunction

  // parity level that gives an even (or odd) count of high levels
  function automatic logic sc_par_level(input logic [SC_DATA_W-1:0] lv, input logic odd_par);
    return (^lv) ^ odd_par;
  endfunction

  function automatic logic sc_par_ok(input logic [SC_DATA_W-1:0] lv, input logic par,
                                     input logic odd_par);
    return ((^lv) ^ par) == odd_par;
  endfunction

  // full frame of line levels indexed by bit period; unused periods released
  function automatic logic [SC_FRAME_W-1:0] sc_build_frame(input logic [SC_DATA_W-1:0] d,
                                                           input sc_cfg_t c);
    logic [SC_FRAME_W-1:0] f;
    logic [SC_DATA_W-1:0]  lv;
    lv = sc_to_levels(d, c);
    f  = '1;
    f[0] = 1'b0;
    f[SC_DATA_W:1] = lv;
    f[SC_PAR_IDX]  = sc_par_level(lv, c.odd_par);
    return f;
  endfunction
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer #(
  parameter int ETU_W = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ETU_W-1:0] etu,
  output logic [IDX_W-1:0] bit_idx,
  output logic             mid,
  output logic             last
);
  logic [ETU_W-1:0] cyc_q;
  logic [ETU_W-1:0] etu_last;
  logic [ETU_W-1:0] etu_half;

  assign etu_last = etu - ETU_W'(1);
  assign etu_half = etu >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cyc_q   <= '0;
      bit_idx <= '0;
    end else if (cyc_q == etu_last) begin
      cyc_q   <= '0;
      bit_idx <= bit_idx + IDX_W'(1);
    end else begin
      cyc_q <= cyc_q + ETU_W'(1);
    end
  end

  assign mid  = run && (cyc_q == etu_half);
  assign last = run && (cyc_q == etu_last);
endmodule

// File: rtl/sc_tx_engine.sv
module sc_tx_engine
  import sc_pkg::*;
#(
  parameter int ETU_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic                 allow,
  input  logic [SC_DATA_W-1:0] data,
  input  sc_cfg_t              cfg,
  input  logic [ETU_W-1:0]     etu,
  input  logic                 line_in,
  output logic                 busy,
  output logic                 drive_low,
  output logic                 done,
  output logic                 rejected,
  output logic                 in_slot
);
  localparam logic [SC_IDX_W-1:0] SLOT = SC_IDX_W'(SC_SLOT_IDX);
  localparam logic [SC_IDX_W-1:0] LAST = SC_IDX_W'(SC_TX_LAST);

  logic [SC_IDX_W-1:0]   bit_idx;
  logic                  mid;
  logic                  last;
  logic [SC_FRAME_W-1:0] frame_q;
  logic                  nack_q;
  logic                  accept;
  logic                  slot_low;

  sc_etu_timer #(.ETU_W(ETU_W), .IDX_W(SC_IDX_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .etu     (etu),
    .bit_idx (bit_idx),
    .mid     (mid),
    .last    (last)
  );

  assign accept    = start_req && allow && !busy;
  assign in_slot   = busy && (bit_idx == SLOT);
  assign slot_low  = in_slot && mid && !line_in;
  assign drive_low = busy && !frame_q[bit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      frame_q  <= '1;
      nack_q   <= 1'b0;
      done     <= 1'b0;
      rejected <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        frame_q  <= sc_build_frame(data, cfg);
        nack_q   <= 1'b0;
        rejected <= 1'b0;
      end else if (busy) begin
        if (slot_low) nack_q <= 1'b1;
        if ((bit_idx == LAST) && last) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          rejected <= nack_q;
          frame_q  <= '1;
        end
      end
    end
  end
endmodule

// File: rtl/sc_rx_engine.sv
module sc_rx_engine
  import sc_pkg::*;
#(
  parameter int ETU_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  sc_cfg_t              cfg,
  input  logic [ETU_W-1:0]     etu,
  input  logic                 line_in,
  output logic                 busy,
  output logic                 drive_low,
  output logic                 valid,
  output logic [SC_DATA_W-1:0] data,
  output logic                 par_err
);
  localparam logic [SC_IDX_W-1:0] PAR  = SC_IDX_W'(SC_PAR_IDX);
  localparam logic [SC_IDX_W-1:0] SLOT = SC_IDX_W'(SC_SLOT_IDX);

  logic [SC_IDX_W-1:0]  bit_idx;
  logic                 mid;
  logic                 last;
  logic [SC_DATA_W-1:0] lv_q;
  logic                 par_q;
  logic                 bad_par;
  logic                 false_start;
  logic                 in_data;

  sc_etu_timer #(.ETU_W(ETU_W), .IDX_W(SC_IDX_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .etu     (etu),
    .bit_idx (bit_idx),
    .mid     (mid),
    .last    (last)
  );

  assign bad_par     = !sc_par_ok(lv_q, par_q, cfg.odd_par);
  assign false_start = mid && (bit_idx == '0) && line_in;
  assign in_data     = (bit_idx != '0) && (bit_idx < PAR);
  assign drive_low   = busy && (bit_idx == SLOT) && bad_par;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      lv_q    <= '0;
      par_q   <= 1'b0;
      valid   <= 1'b0;
      data    <= '0;
      par_err <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!busy) begin
        if (enable && !line_in) busy <= 1'b1;
      end else if (false_start) begin
        busy <= 1'b0;
      end else begin
        if (mid && in_data) lv_q <= {line_in, lv_q[SC_DATA_W-1:1]};
        if (mid && (bit_idx == PAR)) par_q <= line_in;
        if (last && (bit_idx == SLOT)) begin
          busy    <= 1'b0;
          valid   <= 1'b1;
          data    <= sc_from_levels(lv_q, cfg);
          par_err <= bad_par;
        end
      end
    end
  end
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import sc_pkg::*;
#(
  parameter int ETU_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ETU_W-1:0] etu_div,
  input  logic             cfg_msb_first,
  input  logic             cfg_inv_data,
  input  logic             cfg_odd_parity,
  input  logic             tx_start,
  input  logic [7:0]       tx_data,
  output logic             tx_busy,
  output logic             tx_done,
  output logic             tx_rejected,
  output logic             rx_busy,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_par_err,
  input  logic             line_in,
  output logic             line_drive_low
);
  sc_cfg_t cfg;
  logic    tx_drive_low_w;
  logic    rx_drive_low_w;
  logic    tx_in_slot_w;
  logic    rx_enable_w;

  assign cfg = '{msb_first: cfg_msb_first, inv_data: cfg_inv_data, odd_par: cfg_odd_parity};
  assign rx_enable_w = !(tx_busy || tx_start);

  sc_tx_engine #(.ETU_W(ETU_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (tx_start),
    .allow     (!rx_busy),
    .data      (tx_data),
    .cfg       (cfg),
    .etu       (etu_div),
    .line_in   (line_in),
    .busy      (tx_busy),
    .drive_low (tx_drive_low_w),
    .done      (tx_done),
    .rejected  (tx_rejected),
    .in_slot   (tx_in_slot_w)
  );

  sc_rx_engine #(.ETU_W(ETU_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (rx_enable_w),
    .cfg       (cfg),
    .etu       (etu_div),
    .line_in   (line_in),
    .busy      (rx_busy),
    .drive_low (rx_drive_low_w),
    .valid     (rx_valid),
    .data      (rx_data),
    .par_err   (rx_par_err)
  );

  assign line_drive_low = tx_drive_low_w || rx_drive_low_w;
endmodule

// File: rtl/sc_xcvr_chk.sv
module sc_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_start,
  input logic tx_busy,
  input logic tx_done,
  input logic tx_rejected,
  input logic rx_busy,
  input logic rx_valid,
  input logic rx_par_err,
  input logic line_drive_low,
  input logic tx_in_slot,
  input logic tx_drive_low,
  input logic rx_drive_low
);
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low |-> (tx_busy || rx_busy));

  p_start_bit_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> line_drive_low);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  p_slot_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_slot |-> !tx_drive_low);

  p_reject_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_done && !$rose(tx_busy)) |-> $stable(tx_rejected));

  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_err_slot_driven_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_par_err) |-> $past(rx_drive_low));

  p_clean_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_par_err) |-> !$past(rx_drive_low));

  p_half_duplex_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && rx_busy));

  p_tx_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && tx_start) |=> !tx_busy);
endmodule

bind sc_char_xcvr sc_xcvr_chk i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tx_start       (tx_start),
  .tx_busy        (tx_busy),
  .tx_done        (tx_done),
  .tx_rejected    (tx_rejected),
  .rx_busy        (rx_busy),
  .rx_valid       (rx_valid),
  .rx_par_err     (rx_par_err),
  .line_drive_low (line_drive_low),
  .tx_in_slot     (tx_in_slot_w),
  .tx_drive_low   (tx_drive_low_w),
  .rx_drive_low   (rx_drive_low_w)
);

// File: tb/test_sc_char_xcvr.sv
module test_sc_char_xcvr;
  localparam int ETU_W = 12;
  localparam int MAXC  = 16384;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n = 1'b0;
  logic [ETU_W-1:0] etu_div = ETU_W'(5);
  logic             cfg_msb_first = 1'b0, cfg_inv_data = 1'b0, cfg_odd_parity = 1'b0;
  logic             tx_start = 1'b0;
  logic [7:0]       tx_data = 8'h00;
  logic             tx_busy, tx_done, tx_rejected, rx_busy, rx_valid, rx_par_err;
  logic [7:0]       rx_data;
  logic             line_in, line_drive_low;
  logic             card_low = 1'b0;

  assign line_in = !(line_drive_low || card_low);

  sc_char_xcvr #(.ETU_W(ETU_W)) i_sc_char_xcvr (
    .clk(clk), .rst_n(rst_n), .etu_div(etu_div), .cfg_msb_first(cfg_msb_first),
    .cfg_inv_data(cfg_inv_data), .cfg_odd_parity(cfg_odd_parity), .tx_start(tx_start),
    .tx_data(tx_data), .tx_busy(tx_busy), .tx_done(tx_done), .tx_rejected(tx_rejected),
    .rx_busy(rx_busy), .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
    .line_in(line_in), .line_drive_low(line_drive_low)
  );

  // expectation schedule, indexed by the count of rising edges so far
  bit       e_drv [MAXC];
  bit       e_txb [MAXC];
  bit       e_done[MAXC];
  bit       e_rej [MAXC];
  bit       e_rxv [MAXC];
  bit [7:0] e_rxd [MAXC];
  bit       e_perr[MAXC];

  int    cyc = 0;
  int    compared = 0;
  int    mismatched = 0;
  bit    checking = 1'b0;
  bit    reported = 1'b0;
  string cur_tag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s at edge %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  always @(negedge clk) begin
    if (checking && cyc < MAXC) begin
      check(line_drive_low == e_drv[cyc], cur_tag, "line_drive_low", int'(line_drive_low), int'(e_drv[cyc]));
      check(tx_busy == e_txb[cyc], "R2", "tx_busy", int'(tx_busy), int'(e_txb[cyc]));
      check(tx_done == e_done[cyc], "R2", "tx_done", int'(tx_done), int'(e_done[cyc]));
      check(rx_valid == e_rxv[cyc], cur_tag, "rx_valid", int'(rx_valid), int'(e_rxv[cyc]));
      if (e_done[cyc])
        check(tx_rejected == e_rej[cyc], "R6", "tx_rejected", int'(tx_rejected), int'(e_rej[cyc]));
      if (e_rxv[cyc]) begin
        check(rx_data == e_rxd[cyc], cur_tag, "rx_data", int'(rx_data), int'(e_rxd[cyc]));
        check(rx_par_err == e_perr[cyc], "R9", "rx_par_err", int'(rx_par_err), int'(e_perr[cyc]));
      end
    end
  end

  // bench's own statement of the line levels of one frame (bits 0..9)
  function automatic bit [9:0] mk_frame(input bit [7:0] d, input bit msb, input bit inv,
                                        input bit odd);
    bit [9:0] f;
    int highs;
    f = '0;
    highs = 0;
    for (int i = 0; i < 8; i++) begin
      bit b;
      b = msb ? d[7-i] : d[i];
      if (inv) b = !b;
      f[i+1] = b;
      if (b) highs++;
    end
    f[9] = ((highs % 2) == 1) ^ odd;
    return f;
  endfunction

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic set_cfg(input bit msb, input bit inv, input bit odd, input int etu);
    @(negedge clk);
    cfg_msb_first  = msb;
    cfg_inv_data   = inv;
    cfg_odd_parity = odd;
    etu_div        = ETU_W'(etu);
  endtask

  task automatic run_tx(input bit [7:0] d, input int etu, input bit rej, input bit [9:0] fr);
    int t;
    @(negedge clk);
    t = cyc + 1;
    for (int m = 0; m < 12 * etu; m++) begin
      int k;
      k = m / etu;
      e_drv[t+m] = (k < 10) && !fr[k];
      e_txb[t+m] = 1'b1;
    end
    e_done[t+12*etu] = 1'b1;
    e_rej[t+12*etu]  = rej;
    tx_data  = d;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    wait_cyc(t + 10 * etu);
    card_low = rej;
    wait_cyc(t + 11 * etu);
    card_low = 1'b0;
    wait_cyc(t + 12 * etu + 4);
    check(tx_rejected == rej, "R6", "tx_rejected held", int'(tx_rejected), int'(rej));
  endtask

  task automatic run_rx(input bit [9:0] fr, input int etu, input bit [7:0] exp_d,
                        input bit exp_err, input bit poke_tx);
    int n;
    int e;
    @(negedge clk);
    n = cyc;
    e = n + 1;
    for (int c = e + 10 * etu; c < e + 11 * etu; c++) e_drv[c] = exp_err;
    e_rxv[e+11*etu]  = 1'b1;
    e_rxd[e+11*etu]  = exp_d;
    e_perr[e+11*etu] = exp_err;
    for (int k = 0; k < 10; k++) begin
      wait_cyc(n + k * etu);
      card_low = !fr[k];
      if (poke_tx && k == 3) begin
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
      end
    end
    wait_cyc(n + 10 * etu);
    card_low = 1'b0;
    wait_cyc(n + 11 * etu + 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(line_drive_low == 1'b0, "R1", "line_drive_low in reset", int'(line_drive_low), 0);
    check(tx_busy == 1'b0, "R1", "tx_busy in reset", int'(tx_busy), 0);
    check(rx_busy == 1'b0, "R1", "rx_busy in reset", int'(rx_busy), 0);
    check(tx_done == 1'b0, "R1", "tx_done in reset", int'(tx_done), 0);
    check(rx_valid == 1'b0, "R1", "rx_valid in reset", int'(rx_valid), 0);
    check(tx_rejected == 1'b0, "R1", "tx_rejected in reset", int'(tx_rejected), 0);
    rst_n = 1'b1;
    checking = 1'b1;
    repeat (4) @(negedge clk);

    // R3: direct convention, literal line pattern of 0x3B
    cur_tag = "R3";
    set_cfg(1'b0, 1'b0, 1'b0, 5);
    run_tx(8'h3B, 5, 1'b0, 10'b1001110110);

    // R4: inverse convention, literal pattern of 0x3F; card refuses it (R6)
    cur_tag = "R4";
    set_cfg(1'b1, 1'b1, 1'b1, 4);
    run_tx(8'h3F, 4, 1'b1, 10'b1000000110);

    // R5: MSB first, no inversion, odd parity
    cur_tag = "R5";
    set_cfg(1'b1, 1'b0, 1'b1, 7);
    run_tx(8'hA5, 7, 1'b0, mk_frame(8'hA5, 1'b1, 1'b0, 1'b1));

    // R6: flag cleared by a new accepted character, then refused again
    cur_tag = "R6";
    set_cfg(1'b0, 1'b1, 1'b0, 6);
    run_tx(8'h00, 6, 1'b1, mk_frame(8'h00, 1'b0, 1'b1, 1'b0));
    run_tx(8'hFF, 6, 1'b0, mk_frame(8'hFF, 1'b0, 1'b1, 1'b0));

    // R8: receive direct 0x3B
    cur_tag = "R8";
    set_cfg(1'b0, 1'b0, 1'b0, 5);
    run_rx(10'b1001110110, 5, 8'h3B, 1'b0, 1'b0);

    // R4: the inverse pattern is received as 0x3F
    cur_tag = "R4";
    set_cfg(1'b1, 1'b1, 1'b1, 8);
    run_rx(10'b1000000110, 8, 8'h3F, 1'b0, 1'b0);

    // R8: mixed configuration
    cur_tag = "R8";
    set_cfg(1'b1, 1'b0, 1'b1, 6);
    run_rx(mk_frame(8'hC4, 1'b1, 1'b0, 1'b1), 6, 8'hC4, 1'b0, 1'b0);

    // R9: wrong parity level
    cur_tag = "R9";
    set_cfg(1'b0, 1'b0, 1'b0, 5);
    run_rx(mk_frame(8'h5A, 1'b0, 1'b0, 1'b0) ^ 10'h200, 5, 8'h5A, 1'b1, 1'b0);

    // R7: one-cycle low glitch is dropped
    cur_tag = "R7";
    set_cfg(1'b0, 1'b0, 1'b0, 6);
    @(negedge clk);
    card_low = 1'b1;
    @(negedge clk);
    card_low = 1'b0;
    repeat (14 * 6) @(negedge clk);
    check(rx_busy == 1'b0, "R7", "rx_busy after glitch", int'(rx_busy), 0);

    // R10: tx_start during a reception is ignored
    cur_tag = "R10";
    set_cfg(1'b0, 1'b1, 1'b1, 6);
    run_rx(mk_frame(8'h96, 1'b0, 1'b1, 1'b1), 6, 8'h96, 1'b0, 1'b1);

    repeat (5) @(negedge clk);
    checking = 1'b0;
    summary();
    $finish;
  end
endmodule